// File: doc/BRIEF.md
# Program/Erase Status Word Generator

This block builds the status byte that a flash memory returns on reads while an embedded program or erase runs, while an erase is suspended, or after such an operation has failed. The engine sequencing the operation reports its mode. It also supplies the data bit being written, one mask of blocks being erased and one mask of blocks that failed to erase. From these, and from the block index of each read, the block chooses between array data and a status word. It drives a ready/busy flag and advances two read-driven toggle bits.

The block also owns two cycle counters. The first is the block-erase selection window, which restarts on every added block and tells the engine when erasing may begin. The second is the protected-abort interval, during which the status word shows activity even though nothing is written. Both lengths are parameters, so a simulation can run them short.

Top module: `pe_status_gen`

## Requirements
- R1: After reset, with mode idle (code 0), the block selects array data (`sel_array_o`=1), drives `status_o`=0 and `busy_o`=0, and reads do not change this.
- R2: In program mode (code 1), status bit 7 is the complement of `prog_bit7_i`, bits 5, 3 and 2 are 0, and `busy_o`=1.
- R3: Status bit 6 inverts after every read that returns status, at any block, whenever the status comes from a program, an erase (window or running), an error or an abort.
- R4: In erase modes, status bit 7 is 0. Bit 3 is 0 in the selection window (code 2) and 1 while erasing (code 3).
- R5: Status bit 2 inverts only after a status read whose block has its bit set in `erasing_mask_i` (in failure, `failed_mask_i`). Any other cycle leaves it unchanged.
- R6: In suspend (code 4), a read of an erasing block returns status with bit 7=1, bit 6 frozen, bit 2 toggling and bits 5 and 3 at 0. A read of any other block selects array data with `status_o`=0. `busy_o` is 0 in both cases.
- R7: A `fail_i` pulse sets status bit 5 and keeps status selected with `busy_o`=1, whatever the mode, until `clear_err_i`. A program failure shows bit 7 as the complement of `prog_bit7_i`.
- R8: After an erase failure, bits 3 and 5 read 1 and bit 7 reads 0. Bit 2 toggles only on reads of blocks set in `failed_mask_i`.
- R9: `win_done_o` pulses for one cycle exactly `WIN_CYC` cycles after the last `win_add_i` accepted in window mode. A new add restarts the count.
- R10: Leaving window mode clears the window counter, so a later return to window mode without an add gives no `win_done_o`.
- R11: An `abort_start_i` holds `busy_o`=1 for `ABORT_ERASE_CYC` cycles (erase, bit 3=1) or `ABORT_PROG_CYC` cycles (program, bit 3=0). During that time bit 6 toggles and bit 2 stays still. Afterwards the block returns to array data with no error.
- R12: `busy_o` is never 1 while array data is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_mode_i | input | 3 | Engine mode: 0 idle, 1 program, 2 erase window, 3 erasing, 4 suspended |
| prog_bit7_i | input | 1 | Bit 7 of the data being programmed |
| erasing_mask_i | input | NBLK | Blocks selected for erase |
| failed_mask_i | input | NBLK | Blocks that failed to erase |
| fail_i | input | 1 | Engine reports a failed write |
| clear_err_i | input | 1 | Reset command clears the error |
| win_add_i | input | 1 | A block was added to the erase list |
| abort_start_i | input | 1 | All targets protected, start abort interval |
| abort_erase_i | input | 1 | Abort kind: 1 erase, 0 program |
| rd_i | input | 1 | Read strobe |
| rd_blk_i | input | BLK_W | Block index of the read address |
| status_o | output | 8 | Status word |
| sel_array_o | output | 1 | 1 selects array data, 0 selects status |
| busy_o | output | 1 | Ready/busy flag, 1 while busy |
| win_done_o | output | 1 | Selection window expired |

## Verification
A single read can advance both toggle bits in the same cycle. It does so when it returns status from an erasing block during erase, or from a failed block after an erase error. In suspend, the same read advances only bit 2. The bench provokes this with alternating reads of erasing and non-erasing blocks in every mode. A scoreboard models both toggle states from the rules and compares the full byte on each read, so a wrong enable on either bit shows as a byte mismatch. Window expiry and reads also meet during the erase window. The bench checks the pulse position cycle by cycle while it reads status in that mode.

// File: rtl/pe_status_pkg.sv
package pe_status_pkg;
  typedef enum logic [2:0] {
    OP_IDLE      = 3'd0,
    OP_PROG      = 3'd1,
    OP_ERASE_SEL = 3'd2,
    OP_ERASE     = 3'd3,
    OP_SUSP      = 3'd4
  } op_mode_e;

  typedef enum logic [1:0] {
    VIEW_ARRAY,
    VIEW_PROG,
    VIEW_ERASE,
    VIEW_SUSP
  } view_e;

  localparam int unsigned TOG_B6  = 0;
  localparam int unsigned TOG_B2  = 1;
  localparam int unsigned NUM_TOG = 2;
endpackage

// File: rtl/pe_dn_timer.sv
module pe_dn_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             load_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             active_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (clear_i)                  cnt_q <= '0;
    else if (load_i)                   cnt_q <= load_val_i;
    else if (run_i && cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);
  // last counting cycle; a reload in the same cycle wins
  assign expire_o = run_i && !load_i && !clear_i && (cnt_q == CNT_W'(1));
endmodule

// File: rtl/pe_toggle_bank.sv
module pe_toggle_bank #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_tog
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      q_o[g] <= 1'b0;
      else if (en_i[g]) q_o[g] <= ~q_o[g];
    end
  end
endmodule

// File: rtl/pe_status_enc.sv
module pe_status_enc
  import pe_status_pkg::*;
(
  input  view_e       view_i,
  input  logic        prog_bit7_i,
  input  logic        err_i,
  input  logic        started_i,
  input  logic        t6_i,
  input  logic        t2_i,
  output logic [7:0]  status_o
);
  always_comb begin
    status_o = '0;
    unique case (view_i)
      VIEW_PROG: begin
        status_o[7] = ~prog_bit7_i;
        status_o[6] = t6_i;
        status_o[5] = err_i;
      end
      VIEW_ERASE: begin
        status_o[6] = t6_i;
        status_o[5] = err_i;
        status_o[3] = started_i;
        status_o[2] = t2_i;
      end
      VIEW_SUSP: begin
        status_o[7] = 1'b1;
        status_o[6] = t6_i;
        status_o[2] = t2_i;
      end
      default: status_o = '0;
    endcase
  end
endmodule

// File: rtl/pe_status_gen.sv
module pe_status_gen
  import pe_status_pkg::*;
#(
  parameter int unsigned NBLK            = 19,
  parameter int unsigned WIN_CYC         = 50,
  parameter int unsigned ABORT_ERASE_CYC = 100,
  parameter int unsigned ABORT_PROG_CYC  = 4,
  localparam int unsigned BLK_W   = (NBLK > 1) ? $clog2(NBLK) : 1,
  localparam int unsigned TMR_MAX = (WIN_CYC > ABORT_ERASE_CYC) ?
                                    ((WIN_CYC > ABORT_PROG_CYC) ? WIN_CYC : ABORT_PROG_CYC) :
                                    ((ABORT_ERASE_CYC > ABORT_PROG_CYC) ? ABORT_ERASE_CYC : ABORT_PROG_CYC),
  localparam int unsigned TMR_W   = $clog2(TMR_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       op_mode_i,
  input  logic             prog_bit7_i,
  input  logic [NBLK-1:0]  erasing_mask_i,
  input  logic [NBLK-1:0]  failed_mask_i,
  input  logic             fail_i,
  input  logic             clear_err_i,
  input  logic             win_add_i,
  input  logic             abort_start_i,
  input  logic             abort_erase_i,
  input  logic             rd_i,
  input  logic [BLK_W-1:0] rd_blk_i,
  output logic [7:0]       status_o,
  output logic             sel_array_o,
  output logic             busy_o,
  output logic             win_done_o
);
  op_mode_e mode;
  assign mode = op_mode_e'(op_mode_i);

  logic in_sel;
  assign in_sel = (mode == OP_ERASE_SEL);

  // selection window
  logic unused_win_act;
  pe_dn_timer #(.CNT_W(TMR_W)) u_win_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (!in_sel),
    .load_i     (win_add_i && in_sel),
    .run_i      (in_sel),
    .load_val_i (TMR_W'(WIN_CYC)),
    .active_o   (unused_win_act),
    .expire_o   (win_done_o)
  );

  // protected-target abort interval
  logic abort_act, unused_abort_end;
  pe_dn_timer #(.CNT_W(TMR_W)) u_abort_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (1'b0),
    .load_i     (abort_start_i),
    .run_i      (1'b1),
    .load_val_i (abort_erase_i ? TMR_W'(ABORT_ERASE_CYC) : TMR_W'(ABORT_PROG_CYC)),
    .active_o   (abort_act),
    .expire_o   (unused_abort_end)
  );

  logic abort_kind_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            abort_kind_q <= 1'b0;
    else if (abort_start_i) abort_kind_q <= abort_erase_i;
  end

  // sticky failure
  logic err_q, err_erase_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q       <= 1'b0;
      err_erase_q <= 1'b0;
    end else if (fail_i) begin
      err_q       <= 1'b1;
      err_erase_q <= (mode != OP_PROG);
    end else if (clear_err_i) begin
      err_q       <= 1'b0;
    end
  end

  // block qualification of the read address
  logic blk_ok, erasing_hit, failed_hit;
  assign blk_ok      = ({1'b0, rd_blk_i} < (BLK_W+1)'(NBLK));
  assign erasing_hit = blk_ok && erasing_mask_i[rd_blk_i];
  assign failed_hit  = blk_ok && failed_mask_i[rd_blk_i];

  view_e view;
  logic  started, b2_hit;
  always_comb begin
    view    = VIEW_ARRAY;
    started = 1'b0;
    b2_hit  = 1'b0;
    if (err_q) begin
      view    = err_erase_q ? VIEW_ERASE : VIEW_PROG;
      started = err_erase_q;
      b2_hit  = err_erase_q && failed_hit;
    end else if (abort_act) begin
      view    = abort_kind_q ? VIEW_ERASE : VIEW_PROG;
      started = abort_kind_q;
    end else begin
      unique case (mode)
        OP_PROG:      view = VIEW_PROG;
        OP_ERASE_SEL: begin view = VIEW_ERASE; b2_hit = erasing_hit; end
        OP_ERASE:     begin view = VIEW_ERASE; started = 1'b1; b2_hit = erasing_hit; end
        OP_SUSP:      begin
          view   = erasing_hit ? VIEW_SUSP : VIEW_ARRAY;
          b2_hit = erasing_hit;
        end
        default:      view = VIEW_ARRAY;
      endcase
    end
  end

  logic [NUM_TOG-1:0] tog_en, tog_q;
  assign tog_en[TOG_B6] = rd_i && (view == VIEW_PROG || view == VIEW_ERASE);
  assign tog_en[TOG_B2] = rd_i && b2_hit && (view == VIEW_ERASE || view == VIEW_SUSP);

  pe_toggle_bank #(.N(NUM_TOG)) u_tog (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (tog_en),
    .q_o    (tog_q)
  );

  pe_status_enc u_enc (
    .view_i      (view),
    .prog_bit7_i (prog_bit7_i),
    .err_i       (err_q),
    .started_i   (started),
    .t6_i        (tog_q[TOG_B6]),
    .t2_i        (tog_q[TOG_B2]),
    .status_o    (status_o)
  );

  assign sel_array_o = (view == VIEW_ARRAY);
  assign busy_o      = (view == VIEW_PROG) || (view == VIEW_ERASE);
endmodule

// File: rtl/pe_status_chk.sv
module pe_status_chk
  import pe_status_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               rd_i,
  input logic               clear_err_i,
  input logic               err_q,
  input logic               abort_act,
  input logic               sel_array_o,
  input logic               busy_o,
  input logic               win_done_o,
  input logic [2:0]         op_mode_i,
  input logic [7:0]         status_o,
  input logic [NUM_TOG-1:0] tog_q
);
  p_array_not_busy_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_array_o |-> !busy_o);

  p_b6_advance_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !sel_array_o && (op_mode_i != 3'd4 || err_q || abort_act))
    |=> (tog_q[TOG_B6] != $past(tog_q[TOG_B6])));

  p_b2_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(tog_q[TOG_B2]));

  p_err_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[5] && !clear_err_i) |=> status_o[5]);

  p_susp_ready_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_mode_i == 3'd4 && !err_q && !abort_act && !sel_array_o) |-> (status_o[7] && !busy_o));

  p_win_in_sel_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_done_o |-> (op_mode_i == 3'd2));

  p_win_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_done_o |=> !win_done_o);

  p_abort_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_act && !err_q) |-> busy_o);
endmodule

bind pe_status_gen pe_status_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rd_i        (rd_i),
  .clear_err_i (clear_err_i),
  .err_q       (err_q),
  .abort_act   (abort_act),
  .sel_array_o (sel_array_o),
  .busy_o      (busy_o),
  .win_done_o  (win_done_o),
  .op_mode_i   (op_mode_i),
  .status_o    (status_o),
  .tog_q       (tog_q)
);

// File: tb/pe_status_gen_tb_top.sv
module pe_status_gen_tb_top;
  localparam int NB = 8, WC = 6, AE = 10, AP = 3;

  logic clk_i = 1'b0;
  always #5 clk_i = ~clk_i;

  logic          rst_ni;
  logic [2:0]    op_mode_i;
  logic          prog_bit7_i, fail_i, clear_err_i, win_add_i;
  logic          abort_start_i, abort_erase_i, rd_i;
  logic [NB-1:0] erasing_mask_i, failed_mask_i;
  logic [2:0]    rd_blk_i;
  logic [7:0]    status_o;
  logic          sel_array_o, busy_o, win_done_o;

  pe_status_gen #(.NBLK(NB), .WIN_CYC(WC), .ABORT_ERASE_CYC(AE), .ABORT_PROG_CYC(AP)) dut_i (
    .clk_i, .rst_ni, .op_mode_i, .prog_bit7_i, .erasing_mask_i, .failed_mask_i,
    .fail_i, .clear_err_i, .win_add_i, .abort_start_i, .abort_erase_i,
    .rd_i, .rd_blk_i, .status_o, .sel_array_o, .busy_o, .win_done_o
  );

  int n_chk = 0, n_err = 0;
  typedef struct { logic [7:0] st; logic sel; logic busy; string req; } exp_t;
  exp_t q[$];
  bit t6 = 1'b0, t2 = 1'b0;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mk(bit b7, bit b6, bit b5, bit b3, bit b2);
    return {b7, b6, b5, 1'b0, b3, b2, 2'b00};
  endfunction

  // driver: one read, expected item pushed for the monitor
  task automatic rd(int blk, logic [7:0] st, bit sel, bit busy, string req, bit adv6, bit adv2);
    exp_t e;
    @(negedge clk_i);
    rd_blk_i = 3'(blk);
    rd_i = 1'b1;
    e.st = st; e.sel = sel; e.busy = busy; e.req = req;
    q.push_back(e);
    @(negedge clk_i);
    rd_i = 1'b0;
    if (adv6) t6 = ~t6;
    if (adv2) t2 = ~t2;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk_i);
      #3;
      if (rd_i) begin
        if (q.size() == 0) chk("scoreboard underflow", 1, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk({e.req, " status"}, status_o, e.st);
          chk({e.req, " sel"}, sel_array_o, e.sel);
          chk({e.req, " busy"}, busy_o, e.busy);
        end
      end
    end
  end

  initial begin
    #200us;
    n_chk++; n_err++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; op_mode_i = 3'd0; prog_bit7_i = 1'b0; fail_i = 1'b0;
    clear_err_i = 1'b0; win_add_i = 1'b0; abort_start_i = 1'b0; abort_erase_i = 1'b0;
    rd_i = 1'b0; rd_blk_i = '0; erasing_mask_i = '0; failed_mask_i = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #3;
    chk("R1 reset status", status_o, 0);
    chk("R1 reset sel", sel_array_o, 1);
    chk("R1 reset busy", busy_o, 0);
    chk("R9 reset win_done", win_done_o, 0);
    rd(0, 8'h00, 1, 0, "R1 idle read", 0, 0);

    // program
    @(negedge clk_i); op_mode_i = 3'd1; prog_bit7_i = 1'b1;
    rd(0, mk(0, t6, 0, 0, 0), 0, 1, "R2 prog b7", 1, 0);
    rd(3, mk(0, t6, 0, 0, 0), 0, 1, "R3 b6 any block", 1, 0);
    rd(5, mk(0, t6, 0, 0, 0), 0, 1, "R3 b6 again", 1, 0);
    prog_bit7_i = 1'b0;
    rd(1, mk(1, t6, 0, 0, 0), 0, 1, "R2 complement", 1, 0);

    // program failure
    @(negedge clk_i); fail_i = 1'b1;
    @(negedge clk_i); fail_i = 1'b0; op_mode_i = 3'd0;
    rd(2, mk(1, t6, 1, 0, 0), 0, 1, "R7 prog error", 1, 0);
    rd(6, mk(1, t6, 1, 0, 0), 0, 1, "R7 error sticky", 1, 0);
    @(negedge clk_i); clear_err_i = 1'b1;
    @(negedge clk_i); clear_err_i = 1'b0;
    rd(2, 8'h00, 1, 0, "R7 cleared", 0, 0);

    // selection window timing
    @(negedge clk_i); op_mode_i = 3'd2; erasing_mask_i = 8'b0000_0110; win_add_i = 1'b1;
    for (int i = 1; i <= WC + 1; i++) begin
      @(negedge clk_i); win_add_i = 1'b0; #3;
      chk("R9 window expiry", win_done_o, (i == WC));
    end
    @(negedge clk_i); win_add_i = 1'b1;
    for (int i = 1; i <= 3; i++) begin
      @(negedge clk_i); win_add_i = 1'b0; #3;
      chk("R9 before re-add", win_done_o, 0);
    end
    @(negedge clk_i); win_add_i = 1'b1;
    for (int i = 1; i <= WC + 1; i++) begin
      @(negedge clk_i); win_add_i = 1'b0; #3;
      chk("R9 restart", win_done_o, (i == WC));
    end

    // reads in the window
    rd(1, mk(0, t6, 0, 0, t2), 0, 1, "R4 window b3 clear", 1, 1);
    rd(4, mk(0, t6, 0, 0, t2), 0, 1, "R5 other block keeps b2", 1, 0);
    rd(2, mk(0, t6, 0, 0, t2), 0, 1, "R5 erasing block toggles b2", 1, 1);

    // suspend inside the window
    @(negedge clk_i); win_add_i = 1'b1;
    @(negedge clk_i); win_add_i = 1'b0;
    @(negedge clk_i); op_mode_i = 3'd4;
    for (int i = 1; i <= WC + 2; i++) begin
      @(negedge clk_i); #3;
      chk("R10 suspended window", win_done_o, 0);
    end
    @(negedge clk_i); op_mode_i = 3'd2;
    for (int i = 1; i <= WC + 2; i++) begin
      @(negedge clk_i); #3;
      chk("R10 no window after suspend", win_done_o, 0);
    end

    // erasing
    @(negedge clk_i); op_mode_i = 3'd3;
    rd(2, mk(0, t6, 0, 1, t2), 0, 1, "R4 erasing b3 set", 1, 1);
    rd(7, mk(0, t6, 0, 1, t2), 0, 1, "R5 non-erasing block", 1, 0);
    rd(1, mk(0, t6, 0, 1, t2), 0, 1, "R5 erasing block", 1, 1);

    // suspended
    @(negedge clk_i); op_mode_i = 3'd4;
    rd(1, mk(1, t6, 0, 0, t2), 0, 0, "R6 suspend erasing block", 0, 1);
    rd(1, mk(1, t6, 0, 0, t2), 0, 0, "R6 b6 frozen", 0, 1);
    rd(5, 8'h00, 1, 0, "R6 non-erasing array", 0, 0);
    rd(2, mk(1, t6, 0, 0, t2), 0, 0, "R6 erasing again", 0, 1);

    // erase failure
    @(negedge clk_i); op_mode_i = 3'd3; fail_i = 1'b1; failed_mask_i = 8'b0000_0100;
    @(negedge clk_i); fail_i = 1'b0; op_mode_i = 3'd0;
    rd(2, mk(0, t6, 1, 1, t2), 0, 1, "R8 failed block", 1, 1);
    rd(1, mk(0, t6, 1, 1, t2), 0, 1, "R8 good block", 1, 0);
    rd(2, mk(0, t6, 1, 1, t2), 0, 1, "R8 failed block again", 1, 1);
    @(negedge clk_i); clear_err_i = 1'b1;
    @(negedge clk_i); clear_err_i = 1'b0; erasing_mask_i = '0; failed_mask_i = '0;
    rd(2, 8'h00, 1, 0, "R7 cleared after erase", 0, 0);

    // erase abort
    @(negedge clk_i); abort_start_i = 1'b1; abort_erase_i = 1'b1;
    @(negedge clk_i); abort_start_i = 1'b0;
    begin
      exp_t e;
      rd_blk_i = 3'd2; rd_i = 1'b1;
      e.st = mk(0, t6, 0, 1, t2); e.sel = 1'b0; e.busy = 1'b1; e.req = "R11 erase abort read";
      q.push_back(e);
      #3;
      chk("R11 erase abort busy", busy_o, 1);
      t6 = ~t6;
    end
    for (int i = 2; i <= AE + 1; i++) begin
      @(negedge clk_i); rd_i = 1'b0; #3;
      chk("R11 erase abort busy", busy_o, (i <= AE));
    end
    rd(2, 8'h00, 1, 0, "R11 no error after erase abort", 0, 0);

    // program abort
    @(negedge clk_i); prog_bit7_i = 1'b1; abort_start_i = 1'b1; abort_erase_i = 1'b0;
    @(negedge clk_i); abort_start_i = 1'b0;
    begin
      exp_t e;
      rd_blk_i = 3'd4; rd_i = 1'b1;
      e.st = mk(0, t6, 0, 0, 0); e.sel = 1'b0; e.busy = 1'b1; e.req = "R11 prog abort read";
      q.push_back(e);
      #3;
      chk("R11 prog abort busy", busy_o, 1);
      t6 = ~t6;
    end
    for (int i = 2; i <= AP + 1; i++) begin
      @(negedge clk_i); rd_i = 1'b0; #3;
      chk("R11 prog abort busy", busy_o, (i <= AP));
    end
    rd(4, 8'h00, 1, 0, "R11 no error after prog abort", 0, 0);
    #3;
    chk("R12 idle not busy", busy_o, 0);

    repeat (2) @(negedge clk_i);
    chk("scoreboard drained", q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule